// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits in the memory stage of a small pipelined processor. It keeps recently used data words in a direct-mapped array of 16 lines, each holding a block of four words, and answers loads that hit in the same cycle. Each store goes straight through to backing memory as well as into the cache, so memory never holds stale data and a line can be dropped at any time without a write-back.

When a load misses, the block raises `cpu_busy`, fetches all four words of the block from backing memory and returns the requested word after a fixed stall. A store that misses allocates the block the same way, merges the store word into it and writes it through, which takes one more cycle of stall. A store that hits updates the cached word and memory and stalls for one cycle while the memory write completes. The pipeline holds its request steady while `cpu_busy` is high and moves on in the first cycle it is low. Backing memory answers reads combinationally and commits a write at the clock edge in which `mem_wr` is high.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, `cpu_busy` is low while no request is made, and the first load to any address misses.
- R2: The 8-bit word address splits into tag in bits [7:6], line index in bits [5:2] and word offset in bits [1:0]. A line holds the four words that share tag and index.
- R3: A load that hits returns the cached word on `cpu_rdata` in the same cycle with `cpu_busy` low and makes no memory access.
- R4: A load that misses holds `cpu_busy` high for exactly 8 cycles, starting in the cycle the miss is seen. It reads the four words of the block from memory (four cycles with `mem_rd` high) and returns the word with `cpu_busy` low in the ninth cycle.
- R5: A store that misses holds `cpu_busy` high for exactly 9 cycles. It refills the block, then merges the store word, so later loads to any word of that block hit and see the stored value.
- R6: A store that hits holds `cpu_busy` high for exactly one cycle. It updates the cached word, and a following load of that address hits with the new value.
- R7: Every store causes exactly one memory write, with the request's address and data, before `cpu_busy` drops. Memory therefore always holds the latest stored value.
- R8: A line is a hit only when its valid bit is set and its stored tag equals the request tag. Two addresses with the same index and different tags evict each other, so each access misses.
- R9: When `cpu_rd` and `cpu_wr` are both high, the request is a store.
- R10: `mem_rd` and `mem_wr` are never high together, and memory is accessed only in cycles where `cpu_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Load request, held while busy |
| cpu_wr | input | 1 | Store request, held while busy |
| cpu_addr | input | 8 | Word address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when busy is low |
| cpu_busy | output | 1 | Stall to the pipeline |
| mem_rd | output | 1 | Backing memory read strobe |
| mem_wr | output | 1 | Backing memory write strobe |
| mem_addr | output | 8 | Backing memory word address |
| mem_wdata | output | 32 | Backing memory write data |
| mem_rdata | input | 32 | Backing memory read data (combinational) |

## Verification
The bench builds the cache with its default parameters: 2-bit tag, 4-bit index, 2-bit offset, 32-bit words and miss stalls of 8 and 9 cycles. Because the tag is only two bits wide, a 256-word memory model covers the whole address space. The model has a known, computed value in every word, and four addresses that share an index are enough to exercise every eviction case. With the unchanged latencies, the bench can count the stall of each access to the exact cycle. It can also check that the four refill reads and the single write-through land inside each stall window.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WDONE = 2'd2
    } dc_state_e;
endpackage

// File: rtl/dc_addr_split.sv
module dc_addr_split #(
    parameter int TAG_W = 2,
    parameter int IDX_W = 4,
    parameter int OFF_W = 2,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    // tag in the top bits, then index, then word offset
    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign idx = addr[OFF_W +: IDX_W];
    assign off = addr[OFF_W-1:0];
endmodule

// File: rtl/dc_hit_check.sv
module dc_hit_check #(
    parameter int TAG_W = 2
) (
    input  logic             line_vld,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    // stored tag only counts when the line holds valid data
    assign hit = line_vld && (line_tag == req_tag);
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
    parameter int TAG_W       = 2,
    parameter int IDX_W       = 4,
    parameter int OFF_W       = 2,
    parameter int DATA_W      = 32,
    parameter int RD_MISS_CYC = 8,
    parameter int WR_MISS_CYC = 9,
    localparam int ADDR_W     = TAG_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import dc_pkg::*;

    localparam int SETS  = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;
    localparam int SLOTS = SETS * WORDS;
    localparam int CNT_W = $clog2(WR_MISS_CYC + 1);
    localparam logic [CNT_W-1:0] RD_END    = CNT_W'(RD_MISS_CYC);
    localparam logic [CNT_W-1:0] WR_END    = CNT_W'(WR_MISS_CYC);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(WORDS);
    localparam logic [CNT_W-1:0] MERGE_AT  = CNT_W'(WORDS + 1);

    typedef struct packed {
        dc_state_e                     st;
        logic [CNT_W-1:0]              cnt;
        logic                          is_wr;
        logic [SETS-1:0]               vld;
        logic [SETS-1:0][TAG_W-1:0]    tags;
        logic [SLOTS-1:0][DATA_W-1:0]  data;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [OFF_W-1:0] req_off;
    logic             req_hit;
    logic [OFF_W-1:0] fill_off;
    logic [CNT_W-1:0] end_cnt;

    dc_addr_split #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W),
        .OFF_W(OFF_W)
    ) u_split (
        .addr(cpu_addr),
        .tag (req_tag),
        .idx (req_idx),
        .off (req_off)
    );

    dc_hit_check #(
        .TAG_W(TAG_W)
    ) u_hit (
        .line_vld(r_q.vld[req_idx]),
        .line_tag(r_q.tags[req_idx]),
        .req_tag (req_tag),
        .hit     (req_hit)
    );

    // refill word k is fetched while cnt == k+1
    assign fill_off  = OFF_W'(r_q.cnt - 1'b1);
    assign end_cnt   = r_q.is_wr ? WR_END : RD_END;
    assign cpu_rdata = r_q.data[{req_idx, req_off}];

    always_comb begin
        r_d       = r_q;
        cpu_busy  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        case (r_q.st)
            ST_IDLE: begin
                if (cpu_wr) begin
                    cpu_busy = 1'b1;
                    if (req_hit) begin
                        mem_wr = 1'b1;
                        r_d.data[{req_idx, req_off}] = cpu_wdata;
                        r_d.st = ST_WDONE;
                    end else begin
                        r_d.vld[req_idx] = 1'b0;
                        r_d.cnt   = CNT_W'(1);
                        r_d.is_wr = 1'b1;
                        r_d.st    = ST_FILL;
                    end
                end else if (cpu_rd && !req_hit) begin
                    cpu_busy = 1'b1;
                    r_d.vld[req_idx] = 1'b0;
                    r_d.cnt   = CNT_W'(1);
                    r_d.is_wr = 1'b0;
                    r_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                cpu_busy = (r_q.cnt < end_cnt);
                if (r_q.cnt <= FILL_LAST) begin
                    mem_rd   = 1'b1;
                    mem_addr = {req_tag, req_idx, fill_off};
                    r_d.data[{req_idx, fill_off}] = mem_rdata;
                    if (r_q.cnt == FILL_LAST) begin
                        r_d.vld[req_idx]  = 1'b1;
                        r_d.tags[req_idx] = req_tag;
                    end
                end
                if (r_q.is_wr && (r_q.cnt == MERGE_AT)) begin
                    mem_wr = 1'b1;
                    r_d.data[{req_idx, req_off}] = cpu_wdata;
                end
                if (cpu_busy) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WDONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int RD_MISS_CYC = 8,
    parameter int WR_MISS_CYC = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_busy,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    logic [7:0] run_q;
    logic       wseen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            wseen_q <= 1'b0;
        end else begin
            run_q   <= cpu_busy ? ((run_q == 8'hFF) ? run_q : run_q + 8'd1) : 8'd0;
            wseen_q <= cpu_busy ? (wseen_q | mem_wr) : 1'b0;
        end
    end

    p_no_rd_wr_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_mem_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_busy);

    p_store_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (cpu_wr && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

    p_store_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_busy) && cpu_wr) |-> wseen_q);

    p_load_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_busy) && cpu_rd && !cpu_wr) |-> (run_q == 8'(RD_MISS_CYC)));

    p_store_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_busy) && cpu_wr) |-> (run_q == 8'd1 || run_q == 8'(WR_MISS_CYC)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr && !cpu_busy) |=> !(mem_rd || mem_wr) || cpu_busy);
endmodule

bind dcache_wt dcache_wt_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RD_MISS_CYC(RD_MISS_CYC),
    .WR_MISS_CYC(WR_MISS_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_busy (cpu_busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/tb_dcache_wt.sv
module tb_dcache_wt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_busy;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    int n_bad = 0;

    logic [31:0] mem [256];

    always #5 clk = ~clk;

    dcache_wt dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cpu_busy (cpu_busy),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(input int a);
        return 32'hC0DE0000 + 32'(a) * 32'h00010003;
    endfunction

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            if (mem_rd) n_rd <= n_rd + 1;
            if (mem_wr) n_wr <= n_wr + 1;
            if ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && !cpu_busy)) n_bad <= n_bad + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one request; counts stall cycles, checks stall length and load data
    task automatic access(input logic rd, input logic wr, input logic [7:0] a,
                          input logic [31:0] wd, input int exp_busy,
                          input bit chk_data, input logic [31:0] exp_data,
                          input string req);
        int n = 0;
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (cpu_busy && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(n == exp_busy, req, "busy cycles", 32'(n), 32'(exp_busy));
        if (chk_data) check(cpu_rdata == exp_data, req, "load data", cpu_rdata, exp_data);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(cpu_busy == 1'b0, "R1", "busy idle after reset", 32'(cpu_busy), 32'd0);
        check(!mem_rd && !mem_wr, "R1", "memory quiet after reset", 32'({mem_rd, mem_wr}), 32'd0);
    endtask

    task automatic t_read_miss();
        int r0 = n_rd, w0 = n_wr;
        access(1, 0, 8'h05, '0, 8, 1, init_val(8'h05), "R1 R4 first load misses");
        check(n_rd - r0 == 4, "R4", "refill reads", 32'(n_rd - r0), 32'd4);
        check(n_wr == w0, "R4", "no write on load", 32'(n_wr - w0), 32'd0);
    endtask

    task automatic t_read_hits();
        int r0 = n_rd;
        access(1, 0, 8'h04, '0, 0, 1, init_val(8'h04), "R3 hit word 0");
        access(1, 0, 8'h06, '0, 0, 1, init_val(8'h06), "R3 hit word 2");
        access(1, 0, 8'h07, '0, 0, 1, init_val(8'h07), "R2 R3 hit word 3");
        check(n_rd == r0, "R3", "no memory read on hit", 32'(n_rd - r0), 32'd0);
        access(1, 0, 8'h08, '0, 8, 1, init_val(8'h08), "R2 next index misses");
    endtask

    task automatic t_write_hit();
        int w0 = n_wr;
        access(0, 1, 8'h06, 32'hDEAD0006, 1, 0, '0, "R6 store hit stall");
        check(n_wr - w0 == 1, "R7", "one memory write", 32'(n_wr - w0), 32'd1);
        check(mem[8'h06] == 32'hDEAD0006, "R7", "memory updated", mem[8'h06], 32'hDEAD0006);
        access(1, 0, 8'h06, '0, 0, 1, 32'hDEAD0006, "R6 load after store hit");
    endtask

    task automatic t_write_miss();
        int w0 = n_wr, r0 = n_rd;
        access(0, 1, 8'h93, 32'hBEEF0093, 9, 0, '0, "R5 store miss stall");
        check(n_wr - w0 == 1, "R7", "one write on store miss", 32'(n_wr - w0), 32'd1);
        check(n_rd - r0 == 4, "R5", "refill on store miss", 32'(n_rd - r0), 32'd4);
        check(mem[8'h93] == 32'hBEEF0093, "R7", "memory after store miss", mem[8'h93], 32'hBEEF0093);
        access(1, 0, 8'h93, '0, 0, 1, 32'hBEEF0093, "R5 merged word hits");
        access(1, 0, 8'h90, '0, 0, 1, init_val(8'h90), "R5 refilled word hits");
    endtask

    task automatic t_conflict();
        access(1, 0, 8'h45, '0, 8, 1, init_val(8'h45), "R8 other tag evicts");
        access(1, 0, 8'h05, '0, 8, 1, init_val(8'h05), "R8 original tag misses again");
        access(1, 0, 8'h06, '0, 0, 1, 32'hDEAD0006, "R7 refill sees stored value");
        access(1, 0, 8'hC5, '0, 8, 1, init_val(8'hC5), "R8 third tag misses");
    endtask

    task automatic t_both();
        int w0 = n_wr;
        access(1, 0, 8'hC7, '0, 0, 1, init_val(8'hC7), "R9 line present");
        access(1, 1, 8'hC7, 32'h12340007, 1, 0, '0, "R9 both strobes act as store");
        check(n_wr - w0 == 1, "R9", "store issued", 32'(n_wr - w0), 32'd1);
        check(mem[8'hC7] == 32'h12340007, "R9", "memory holds store", mem[8'hC7], 32'h12340007);
        access(1, 0, 8'hC7, '0, 0, 1, 32'h12340007, "R9 load sees store");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hits();
        t_write_hit();
        t_write_miss();
        t_conflict();
        t_both();
        @(negedge clk);
        check(n_bad == 0, "R10", "memory strobe rule", 32'(n_bad), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule